// File: doc/BRIEF.md
# Word Serializer with Internal Wrap Select

This block turns a 10-bit parallel word, already line-coded upstream, into a serial bit stream at ten times the word rate. Everything runs on one bit-rate clock. A one-cycle strobe, `byte_edge`, marks each rising edge of the word clock, and the word on `tx_word` is captured in that cycle. The captured word goes into a shift register. Its bits leave least significant first, starting a fixed number of bit cycles after the capturing edge. Words follow each other with no idle bits between them.

A wrap control, `loop_en`, picks where the stream goes. With wrap off, the stream drives `ser_out` and the receive-side selector passes the external serial input through to `rx_sel_out`. With wrap on, `ser_out` sits at logic 0 and the stream is fed straight into the receive-side selector. A new wrap setting is taken up only at a word boundary, so no word is ever split between the two paths.

Top module: `ser_wrap_tx`

## Requirements
- R1: `tx_word` is captured only in a cycle where `byte_edge` is 1. Its value in every other cycle has no effect on the stream.
- R2: Each captured word takes exactly WORD_W (10) consecutive bit cycles. Words sent at the strobe rate follow each other with no gap bits.
- R3: Bits are sent in ascending order. Bit 0 (the LSB) goes first and bit WORD_W-1 goes last.
- R4: Bit 0 of a word captured at clock edge t is visible after edge t+LAT (LAT = 8). Bit b is visible after edge t+LAT+b.
- R5: While wrap is off, `ser_out` carries the stream and `rx_sel_out` equals `ext_rx_in`.
- R6: While wrap is on, `ser_out` is held at 0 and `rx_sel_out` carries the stream bit.
- R7: During reset, `ser_out` is 0 and wrap is off, so `rx_sel_out` equals `ext_rx_in`. After reset and before the first word load, the stream is 0.
- R8: `loop_en` is sampled only at the clock edge that loads a new word (the edge that starts its bit 0). A change in the middle of a word leaves the rest of that word on the old path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_edge | input | 1 | One-cycle strobe marking a word clock rising edge |
| tx_word | input | WORD_W | Coded parallel word to send |
| loop_en | input | 1 | 1 = wrap the stream internally, 0 = drive it out |
| ext_rx_in | input | 1 | External serial input for the receiver |
| ser_out | output | 1 | External serial output |
| rx_sel_out | output | 1 | Serial bit handed to the receiver |

## Verification
On every cycle, the assertions check these properties:
- the external output stays at 0 while wrap is active;
- the path setting only changes on load edges;
- the shift register moves down by one bit between loads and takes the held word on a load;
- the bit phase wraps after WORD_W slots.

Only the bench scenarios can show the end-to-end properties at the ports:
- the exact latency from capture to bit 0;
- LSB-first order across all 1024 word values;
- that `tx_word` changes between strobes are ignored;
- that a mid-word change of `loop_en` leaves that word on its old path.

// File: rtl/ser_wrap_pkg.sv
// Package: shared types for the word serializer.
// Assumes: a single bit-rate clock domain.
package ser_wrap_pkg;
    // Which source feeds the receiver side.
    typedef enum logic {
        PATH_EXT  = 1'b0,
        PATH_WRAP = 1'b1
    } path_e;
endpackage

// File: rtl/swt_phase_gen.sv
// Bit-slot counter. Counts WORD_W slots per word and restarts when the word
// strobe arrives. Flags the slot on which the next word is loaded.
// Assumes: byte_edge arrives once every WORD_W cycles, or not at all.
module swt_phase_gen #(
    parameter int WORD_W = 10,
    parameter int LAT    = 8,
    localparam int PH_W  = $clog2(WORD_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_edge,
    output logic [PH_W-1:0] phase,
    output logic            load_slot
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(WORD_W - 1);
    localparam logic [PH_W-1:0] LOAD_PH = PH_W'(LAT - 1);

    // Advance the slot count, realigning to zero on each word strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (byte_edge)
            phase <= '0;
        else if (phase == LAST_PH)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // The load happens LAT edges after the strobe.
    always_comb load_slot = (phase == LOAD_PH);
endmodule

// File: rtl/swt_word_hold.sv
// Input latch. Captures the parallel word on the word strobe and holds it
// until the shifter takes it.
// Assumes: LAT <= WORD_W, so the next capture comes after the load.
module swt_word_hold #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_edge,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] hold_word
);
    // Capture the word only when the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_word <= '0;
        else if (byte_edge)
            hold_word <= tx_word;
    end
endmodule

// File: rtl/swt_shifter.sv
// Parallel-in, serial-out register. Bit 0 is the current serial bit.
// Assumes: load_slot comes once every WORD_W cycles.
module swt_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_slot,
    input  logic [WORD_W-1:0] hold_word,
    output logic [WORD_W-1:0] shreg
);
    logic [WORD_W-1:0] shift_nxt;

    // Build the shifted value bit by bit, filling the top with 0.
    for (genvar i = 0; i < WORD_W; i++) begin : g_sh
        if (i == WORD_W - 1) begin : g_top
            assign shift_nxt[i] = 1'b0;
        end else begin : g_mid
            assign shift_nxt[i] = shreg[i+1];
        end
    end

    // Load a new word on the load slot, otherwise shift down by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (load_slot)
            shreg <= hold_word;
        else
            shreg <= shift_nxt;
    end
endmodule

// File: rtl/swt_path_sel.sv
// Output and receive-side path steering. The wrap setting is sampled only
// at word loads.
// Assumes: stream_bit is the current serial bit.
module swt_path_sel
    import ser_wrap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_slot,
    input  logic  loop_en,
    input  logic  stream_bit,
    input  logic  ext_rx_in,
    output path_e path_q,
    output logic  ser_out,
    output logic  rx_sel_out
);
    // Take up a new wrap setting only at a word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            path_q <= PATH_EXT;
        else if (load_slot)
            path_q <= loop_en ? PATH_WRAP : PATH_EXT;
    end

    // Steer the stream: out to the pin, or into the receive selector.
    always_comb begin
        if (path_q == PATH_WRAP) begin
            ser_out    = 1'b0;
            rx_sel_out = stream_bit;
        end else begin
            ser_out    = stream_bit;
            rx_sel_out = ext_rx_in;
        end
    end
endmodule

// File: rtl/ser_wrap_tx.sv
// Top level: word serializer with an internal wrap path.
// Sends words LSB first, LAT bit cycles after capture, with no gaps.
// Assumes: clk runs at the bit rate and byte_edge marks the word clock.
module ser_wrap_tx
    import ser_wrap_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int LAT    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_edge,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              loop_en,
    input  logic              ext_rx_in,
    output logic              ser_out,
    output logic              rx_sel_out
);
    localparam int PH_W = $clog2(WORD_W);

    logic [PH_W-1:0]   phase;
    logic              load_slot;
    logic [WORD_W-1:0] hold_word;
    logic [WORD_W-1:0] shreg;
    path_e             path_q;

    swt_phase_gen #(.WORD_W(WORD_W), .LAT(LAT)) u_phase (
        .clk(clk), .rst_n(rst_n), .byte_edge(byte_edge),
        .phase(phase), .load_slot(load_slot)
    );

    swt_word_hold #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .byte_edge(byte_edge),
        .tx_word(tx_word), .hold_word(hold_word)
    );

    swt_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_slot(load_slot),
        .hold_word(hold_word), .shreg(shreg)
    );

    swt_path_sel u_path (
        .clk(clk), .rst_n(rst_n), .load_slot(load_slot),
        .loop_en(loop_en), .stream_bit(shreg[0]), .ext_rx_in(ext_rx_in),
        .path_q(path_q), .ser_out(ser_out), .rx_sel_out(rx_sel_out)
    );
endmodule

// File: rtl/ser_wrap_tx_chk.sv
// Assertion checker for ser_wrap_tx, attached with bind.
module ser_wrap_tx_chk
    import ser_wrap_pkg::*;
#(
    parameter int WORD_W = 10,
    localparam int PH_W  = $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_edge,
    input logic [PH_W-1:0]   phase,
    input logic              load_slot,
    input logic [WORD_W-1:0] hold_word,
    input logic [WORD_W-1:0] shreg,
    input path_e             path_q,
    input logic              ser_out
);
    // R6: the external pin stays at 0 while wrap is active.
    p_static_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (path_q == PATH_WRAP) |-> (ser_out == 1'b0));

    // R8: the path setting changes only on a load edge.
    p_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_slot |=> $stable(path_q));

    // R3: between loads the register moves down one bit, LSB first.
    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_slot |=> (shreg[WORD_W-2:0] == $past(shreg[WORD_W-1:1])));

    // R1: a load takes the word held from the last capture.
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_slot |=> (shreg == $past(hold_word)));

    // R2: the slot count wraps to zero after WORD_W slots.
    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_edge && phase == PH_W'(WORD_W - 1)) |=> (phase == '0));
endmodule

bind ser_wrap_tx ser_wrap_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_edge(byte_edge), .phase(phase),
    .load_slot(load_slot), .hold_word(hold_word), .shreg(shreg),
    .path_q(path_q), .ser_out(ser_out)
);

// File: tb/ser_wrap_tx_test.sv
// Bench: sends all 1024 words with wrap off, then a wrap-toggling run.
module ser_wrap_tx_test;
    localparam int W     = 10;
    localparam int LAT   = 8;
    localparam int NOFF  = 1024;
    localparam int NWORD = 1280;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         byte_edge = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         loop_en = 1'b0;
    logic         ext_rx_in = 1'b0;
    logic         ser_out;
    logic         rx_sel_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    ser_wrap_tx #(.WORD_W(W), .LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .byte_edge(byte_edge), .tx_word(tx_word),
        .loop_en(loop_en), .ext_rx_in(ext_rx_in),
        .ser_out(ser_out), .rx_sel_out(rx_sel_out)
    );

    always #2.5 clk = ~clk;

    // Word j of the sweep: 387 is odd, so this visits every 10-bit value.
    function automatic logic [W-1:0] word_of(int j);
        return W'((j * 387) % 1024);
    endfunction

    // Wrap mode of word j: off for the sweep, then on/off in blocks of four.
    function automatic logic mode_of(int j);
        if (j < NOFF) return 1'b0;
        return 1'(((j - NOFF) >> 2) & 1);
    endfunction

    // loop_en driven for edge k: it switches 3 edges into a word slot.
    function automatic logic lp_of(int k);
        if (k < 3) return 1'b0;
        return mode_of((k - 3) / W);
    endfunction

    function automatic logic ext_of(int k);
        return 1'(k ^ (k >> 3));
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        // R7: outputs during reset.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ext_rx_in = 1'(i);
        end
        @(negedge clk);
        check("R7 reset ser_out", ser_out, 1'b0);
        check("R7 reset rx_sel_out", rx_sel_out, ext_rx_in);
        ext_rx_in = ~ext_rx_in;
        #0.1;
        check("R7 reset rx_sel_out follows ext", rx_sel_out, ext_rx_in);
        rst_n = 1'b1;

        for (int k = 0; k < NWORD * W + LAT + 2; k++) begin
            int j;
            // Drive the inputs for edge k.
            j = k / W;
            byte_edge = (k % W == 0) && (j < NWORD);
            // R1: tx_word holds garbage outside the strobe cycle.
            tx_word   = byte_edge ? word_of(j) : ~word_of(j + 3);
            loop_en   = lp_of(k);
            ext_rx_in = ext_of(k);
            @(negedge clk);
            // Check after edge k.
            if (k < LAT) begin
                check("R7 idle stream", ser_out, 1'b0);
                check("R7 idle rx", rx_sel_out, ext_of(k));
            end else if ((k - LAT) / W < NWORD) begin
                int   wj, b;
                logic eb, m;
                string tag;
                wj = (k - LAT) / W;
                b  = (k - LAT) % W;
                eb = word_of(wj)[b];
                m  = mode_of(wj);
                if (lp_of(k) != m)      tag = "R8 mid-word change";
                else if (b == 0)        tag = "R4 first bit";
                else if (b == W - 1)    tag = "R2 last bit";
                else                    tag = "R3 R1 bit order";
                if (m) begin
                    check({tag, " R6 pin static"}, ser_out, 1'b0);
                    check({tag, " R6 wrap stream"}, rx_sel_out, eb);
                end else begin
                    check({tag, " R5 stream"}, ser_out, eb);
                    check({tag, " R5 ext pass"}, rx_sel_out, ext_of(k));
                end
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 60000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule